// File: doc/BRIEF.md
# Configurable Two-Stage Input Synchronizer

This block conditions a vector of raw pad inputs before they reach the input data register and the interrupt logic. Every pin passes through two cascaded stages. Each stage, chosen per pin by its own 2-bit mode field, is either transparent, takes its sample on the falling edge of the IO clock, or takes its sample on the rising edge. Stage one sees the raw pad level. Stage two sees the output of stage one. The output of stage two is the conditioned vector.

Each stage keeps one rising-edge flop and one falling-edge flop for every pin, and both flops sample all the time. The mode selects which of the raw input, the falling sample or the rising sample is passed on. Mode fields are registered on the rising edge, so a new mode is applied from the next clock onward. Reset clears them to full bypass. A registered input data view captures the conditioned level on each rising edge.

Top module: `pin_sync_top`

## Requirements
- R1: While reset (synchronous, active high) is applied, and on the first rising edge after it, `pin_level_o` is all zeros and both stages are in bypass, so `cond_o` equals `pad_i`.
- R2: When both stages of a pin are in mode 0 (no synchronization), `cond_o` for that pin follows `pad_i` within the same cycle, with no clock edge in between.
- R3: A stage in mode 2 passes on the value its input had at the last rising clock edge. With both stages in mode 2, a change on `pad_i` shows up on `cond_o` after exactly two rising edges.
- R4: A stage in mode 1 passes on the value its input had at the last falling clock edge.
- R5: Stage one takes `pad_i` as its input. Stage two takes the output of stage one as its input, and the output of stage two drives `cond_o`.
- R6: Each pin's two mode fields act only on that pin. Bits [2i+1:2i] of `mode1_i` and `mode2_i` belong to pin i.
- R7: A value on `mode1_i` or `mode2_i` is applied starting at the rising edge that samples it. Before that edge the previous mode stays in force.
- R8: `pin_level_o` is a register that, on each rising edge, loads `cond_o` as seen just before that edge. It has one bit per pin, and 1 means high.
- R9: Mode 3 behaves exactly like mode 2 (rising-edge sampling).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | IO clock; rising and falling edges both used |
| rst | input | 1 | Synchronous active-high reset |
| pad_i | input | NPIN | Raw pad levels |
| mode1_i | input | 2*NPIN | First-stage mode, 2 bits per pin |
| mode2_i | input | 2*NPIN | Second-stage mode, 2 bits per pin |
| cond_o | output | NPIN | Conditioned pin vector |
| pin_level_o | output | NPIN | Registered input data view |

## Verification
The bench goes after the cases where the two stages interact. The first is falling-then-rising, where a design that wired the flops to the wrong edge would show a half-cycle shift. The second is the two-edge latency with both stages on the rising edge, where a missing cascade would show up one cycle early. It also checks that mode 3 is a real alias of mode 2; a decoder that treated 3 as bypass would pass the raw pad straight through. One directed step changes the mode and the pad together, to catch a design that applied the mode in the same cycle instead of at the next edge. Random per-pin modes catch bit-slicing errors, where the field of one pin would steer a neighbour.

// File: rtl/pin_sync_pkg.sv
package pin_sync_pkg;
  localparam logic [1:0] SYNC_BYPASS = 2'd0;
  localparam logic [1:0] SYNC_FALL   = 2'd1;
  localparam logic [1:0] SYNC_RISE   = 2'd2;
  localparam logic [1:0] SYNC_RISE_B = 2'd3;

  function automatic logic sync_tap(input logic [1:0] mode, input logic raw,
                                    input logic fall_s, input logic rise_s);
    if (mode == SYNC_BYPASS) return raw;
    else if (mode == SYNC_FALL) return fall_s;
    else return rise_s;
  endfunction
endpackage

// File: rtl/pin_sync_stage.sv
module pin_sync_stage
  import pin_sync_pkg::*;
#(
  parameter int NPIN = 25
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NPIN-1:0]      d_i,
  input  logic [NPIN-1:0][1:0] mode_i,
  output logic [NPIN-1:0][1:0] mode_q_o,
  output logic [NPIN-1:0]      q_o
);
  logic [NPIN-1:0][1:0] mode_q;
  logic [NPIN-1:0]      rise_q;
  logic [NPIN-1:0]      fall_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
      rise_q <= '0;
    end else begin
      mode_q <= mode_i;
      rise_q <= d_i;
    end
  end

  always_ff @(negedge clk) begin
    if (rst) fall_q <= '0;
    else     fall_q <= d_i;
  end

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    assign q_o[i] = sync_tap(mode_q[i], d_i[i], fall_q[i], rise_q[i]);

    // R3 / R9: rising-edge modes present the input seen at the previous edge
    a_r3_rise_capture: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && mode_q[i][1]) |-> (q_o[i] == $past(d_i[i])));
  end

  assign mode_q_o = mode_q;

  // R7: a mode takes effect from the edge that samples it
  a_r7_mode_applied: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (mode_q == $past(mode_i)));
endmodule

// File: rtl/pin_level_reg.sv
module pin_level_reg #(
  parameter int NPIN = 25
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NPIN-1:0] cond_i,
  output logic [NPIN-1:0] level_o
);
  always_ff @(posedge clk) begin
    if (rst) level_o <= '0;
    else     level_o <= cond_i;
  end

  // R8: register follows the conditioned vector one edge later
  a_r8_level_tracks: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (level_o == $past(cond_i)));

  // R1: the first edge after reset still shows cleared levels
  a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (level_o == '0));
endmodule

// File: rtl/pin_sync_top.sv
module pin_sync_top #(
  parameter int NPIN = 25
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NPIN-1:0]      pad_i,
  input  logic [NPIN-1:0][1:0] mode1_i,
  input  logic [NPIN-1:0][1:0] mode2_i,
  output logic [NPIN-1:0]      cond_o,
  output logic [NPIN-1:0]      pin_level_o
);
  localparam int MODE_W = 2 * NPIN;

  logic [NPIN-1:0]      mid;
  logic [NPIN-1:0][1:0] m1_q;
  logic [NPIN-1:0][1:0] m2_q;

  pin_sync_stage #(.NPIN(NPIN)) u_first (
    .clk(clk), .rst(rst), .d_i(pad_i), .mode_i(mode1_i),
    .mode_q_o(m1_q), .q_o(mid)
  );

  pin_sync_stage #(.NPIN(NPIN)) u_second (
    .clk(clk), .rst(rst), .d_i(mid), .mode_i(mode2_i),
    .mode_q_o(m2_q), .q_o(cond_o)
  );

  pin_level_reg #(.NPIN(NPIN)) u_level (
    .clk(clk), .rst(rst), .cond_i(cond_o), .level_o(pin_level_o)
  );

  // R2: full bypass leaves the path transparent
  a_r2_bypass: assert property (@(posedge clk) disable iff (rst)
    ((m1_q == MODE_W'(0)) && (m2_q == MODE_W'(0))) |-> (cond_o == pad_i));
endmodule

// File: tb/sim_pin_sync_top.sv
module sim_pin_sync_top;
  localparam int NPIN = 25;

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic [NPIN-1:0]      pad = '0;
  logic [NPIN-1:0][1:0] m1 = '0;
  logic [NPIN-1:0][1:0] m2 = '0;
  logic [NPIN-1:0]      cond_o;
  logic [NPIN-1:0]      pin_level_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pin_sync_top #(.NPIN(NPIN)) u0 (
    .clk(clk), .rst(rst), .pad_i(pad), .mode1_i(m1), .mode2_i(m2),
    .cond_o(cond_o), .pin_level_o(pin_level_o)
  );

  // Reference model built from the requirements
  logic [NPIN-1:0][1:0] rq1, rq2;
  logic [NPIN-1:0]      rr1, rf1, rr2, rf2, rlev;
  logic [NPIN-1:0]      e1, e2;

  function automatic logic [NPIN-1:0] pick(input logic [NPIN-1:0][1:0] m,
      input logic [NPIN-1:0] d, input logic [NPIN-1:0] f, input logic [NPIN-1:0] r);
    logic [NPIN-1:0] o;
    for (int i = 0; i < NPIN; i++)
      o[i] = (m[i] == 2'd0) ? d[i] : (m[i] == 2'd1) ? f[i] : r[i];
    return o;
  endfunction

  assign e1 = pick(rq1, pad, rf1, rr1);
  assign e2 = pick(rq2, e1, rf2, rr2);

  always @(posedge clk) begin
    if (rst) begin
      rq1 <= '0; rq2 <= '0; rr1 <= '0; rr2 <= '0; rlev <= '0;
    end else begin
      rq1 <= m1; rq2 <= m2; rr1 <= pad; rr2 <= e1; rlev <= e2;
    end
  end

  always @(negedge clk) begin
    if (rst) begin rf1 <= '0; rf2 <= '0; end
    else begin rf1 <= pad; rf2 <= e1; end
  end

  task automatic cmp(input string req, input logic [NPIN-1:0] act,
                     input logic [NPIN-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_all(input string req);
    cmp(req, cond_o, e2);
    cmp("R8 level register", pin_level_o, rlev);
  endtask

  // drive just after a rising edge, check after the following falling edge
  task automatic step(input logic [NPIN-1:0] p, input logic [NPIN-1:0][1:0] a,
                      input logic [NPIN-1:0][1:0] b, input string req);
    @(posedge clk); #1;
    pad = p; m1 = a; m2 = b;
    #2;
    check_all(req);
  endtask

  function automatic logic [NPIN-1:0][1:0] fill(input logic [1:0] v);
    logic [NPIN-1:0][1:0] o;
    for (int i = 0; i < NPIN; i++) o[i] = v;
    return o;
  endfunction

  function automatic logic [NPIN-1:0][1:0] rnd_modes();
    logic [NPIN-1:0][1:0] o;
    for (int i = 0; i < NPIN; i++) o[i] = 2'($urandom());
    return o;
  endfunction

  function automatic logic [NPIN-1:0] rnd_pad();
    return NPIN'({$urandom(), $urandom()});
  endfunction

  initial begin
    void'($urandom(32'd7));
    // R1: reset state
    pad = rnd_pad();
    repeat (2) @(posedge clk);
    #3;
    cmp("R1 level in reset", pin_level_o, '0);
    cmp("R1 bypass in reset", cond_o, pad);
    @(posedge clk); #1; rst = 1'b0;
    #2;
    cmp("R1 first cycle after reset", pin_level_o, '0);

    // R2: full bypass follows pad combinationally
    for (int k = 0; k < 20; k++) begin
      step(rnd_pad(), fill(2'd0), fill(2'd0), "R2 bypass");
      cmp("R2 same-cycle follow", cond_o, pad);
    end

    // R3: both rising, two-edge latency from a step
    step('0, fill(2'd2), fill(2'd2), "R3 settle");
    step('0, fill(2'd2), fill(2'd2), "R3 settle");
    step('0, fill(2'd2), fill(2'd2), "R3 settle");
    step('1, fill(2'd2), fill(2'd2), "R3 step");
    cmp("R3 no change same cycle", cond_o, '0);
    step('1, fill(2'd2), fill(2'd2), "R3 step");
    cmp("R3 no change after one edge", cond_o, '0);
    step('1, fill(2'd2), fill(2'd2), "R3 step");
    cmp("R3 visible after two edges", cond_o, '1);
    for (int k = 0; k < 20; k++) step(rnd_pad(), fill(2'd2), fill(2'd2), "R3 random");

    // R9: mode 3 matches mode 2
    for (int k = 0; k < 20; k++) step(rnd_pad(), fill(2'd3), fill(2'd3), "R9 mode 3 alias");
    for (int k = 0; k < 10; k++) step(rnd_pad(), fill(2'd3), fill(2'd2), "R9 mixed 3 and 2");

    // R4: falling-edge stages
    for (int k = 0; k < 20; k++) step(rnd_pad(), fill(2'd1), fill(2'd1), "R4 both falling");
    for (int k = 0; k < 20; k++) step(rnd_pad(), fill(2'd1), fill(2'd2), "R5 fall then rise");
    for (int k = 0; k < 20; k++) step(rnd_pad(), fill(2'd2), fill(2'd1), "R5 rise then fall");
    for (int k = 0; k < 20; k++) step(rnd_pad(), fill(2'd0), fill(2'd1), "R4 bypass then fall");

    // R7: new mode only from the sampling edge
    for (int k = 0; k < 4; k++) step('1, fill(2'd0), fill(2'd0), "R7 hold high");
    step('0, fill(2'd2), fill(2'd2), "R7 switch");
    cmp("R7 old bypass still in force", cond_o, '0);
    for (int k = 0; k < 3; k++) step('1, fill(2'd2), fill(2'd2), "R7 rising after switch");
    for (int k = 0; k < 3; k++) step('0, fill(2'd0), fill(2'd1), "R7 back to bypass/fall");

    // R6: per-pin random modes
    for (int k = 0; k < 200; k++) step(rnd_pad(), rnd_modes(), rnd_modes(), "R6 per-pin modes");

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule